// File: doc/BRIEF.md
# Programmable Tap Delay Controller

This block holds the control state of a programmable I/O delay element. A tap count of `TAP_W` bits (nine by default) sets how many control-clock cycles a data input is delayed before it reaches the data output. The data path is a cycle-based model of the delay line: each tap is one clock of delay, and a count of zero passes the input straight through.

The delay mode is chosen by a parameter. In fixed mode the count never leaves its initial value. In stepping mode a step strobe raises or lowers the count by one tap. In load mode a load strobe copies a parallel value into the count, and steps are also accepted. A count change is honoured only while voltage/temperature tracking is switched off. A request made while tracking is on is ignored and sets a sticky usage-error flag. Fixed mode has its own usage rule: tracking must stay on for as long as the delay controller has not reported ready.

While the controller's ready input is low, the element is held at its initial count. The block reset is asynchronous and active low, and it is released synchronously inside the block.

Top module: `tapdly_ctl`

## Requirements
- R1: While reset is active and just after it, `tap_out` equals `INIT_TAP`, `usage_err` is 0 and `dout` is 0.
- R2: While `ctl_rdy` is low, the next edge puts the count back to `INIT_TAP`, and load or step requests have no effect.
- R3: In stepping and load modes, with `ctl_rdy`=1 and `vt_track`=0, `step_en`=1 changes the count at the next edge: `step_up`=1 adds one tap and `step_up`=0 removes one.
- R4: Steps saturate: an up step at 511 leaves 511, and a down step at 0 leaves 0.
- R5: In load mode, with `vt_track`=0, `tap_load`=1 copies `tap_in` into the count at the next edge, and a load takes priority over a step issued in the same cycle.
- R6: In stepping and load modes, any request that the mode accepts and that is made while `vt_track`=1 (with `ctl_rdy`=1) leaves the count unchanged and sets `usage_err`. The flag stays set until reset.
- R7: In fixed mode the count stays at `INIT_TAP` whatever the requests, and requests raise no error. `usage_err` is set when `vt_track`=0 while `ctl_rdy`=0.
- R8: In stepping mode `tap_load` is ignored and raises no error.
- R9: `dout` equals the `din` value from `tap_out` cycles earlier; with a count of 0, `dout` follows `din` directly.
- R10: `tap_out` is the registered count: a request changes it only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_rdy | input | 1 | Delay controller ready |
| vt_track | input | 1 | Voltage/temperature tracking enable |
| tap_load | input | 1 | Load request (load mode) |
| step_en | input | 1 | Step request |
| step_up | input | 1 | Step direction, 1 = up, 0 = down |
| tap_in | input | TAP_W | Value to load |
| din | input | 1 | Data into the delay line |
| dout | output | 1 | Delayed data |
| tap_out | output | TAP_W | Current registered tap count |
| usage_err | output | 1 | Sticky illegal-usage flag |

## Verification
Three instances run side by side on shared stimulus, one per mode, so that a single request pattern shows which modes accept it and which ignore it. Combined load-and-step cycles separate load priority from a plain step. Repeated steps at both ends of the range separate saturation from wrap-around. Requests made with tracking on, followed by legal requests, separate the sticky error from a one-cycle pulse and show that tracking blocks changes only while it is on. Random data streams at tap counts of three and zero tell a correct delay from an off-by-one one and confirm the zero-count pass-through.

// File: rtl/tapdly_pkg.sv
package tapdly_pkg;
  typedef enum logic [1:0] {
    DM_FIXED   = 2'd0,
    DM_STEP    = 2'd1,
    DM_LOAD    = 2'd2
  } dly_mode_e;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_INC  = 2'd2,
    OP_DEC  = 2'd3
  } tap_op_e;
endpackage

// File: rtl/tapdly_req_dec.sv
module tapdly_req_dec
  import tapdly_pkg::*;
#(
  parameter dly_mode_e MODE = DM_LOAD
) (
  input  logic    ctl_rdy,
  input  logic    vt_track,
  input  logic    tap_load,
  input  logic    step_en,
  input  logic    step_up,
  output tap_op_e op,
  output logic    viol
);
  tap_op_e raw_op;
  logic    accepted;

  // Raw request, load before step
  always_comb begin
    if (tap_load)     raw_op = OP_LOAD;
    else if (step_en) raw_op = step_up ? OP_INC : OP_DEC;
    else              raw_op = OP_HOLD;
  end

  // Mode filter: which raw requests the mode accepts at all
  always_comb begin
    case (MODE)
      DM_LOAD:  accepted = (raw_op != OP_HOLD);
      DM_STEP:  accepted = step_en;
      default:  accepted = 1'b0;
    endcase
  end

  always_comb begin
    op   = OP_HOLD;
    viol = 1'b0;
    if (MODE == DM_FIXED) begin
      viol = !ctl_rdy && !vt_track;
    end else if (ctl_rdy && accepted) begin
      if (vt_track) viol = 1'b1;
      else if (MODE == DM_STEP) op = step_up ? OP_INC : OP_DEC;
      else op = raw_op;
    end
  end
endmodule

// File: rtl/tapdly_tap_reg.sv
module tapdly_tap_reg
  import tapdly_pkg::*;
#(
  parameter int unsigned TAP_W    = 9,
  parameter int unsigned INIT_TAP = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_rdy,
  input  tap_op_e          op,
  input  logic [TAP_W-1:0] tap_in,
  output logic [TAP_W-1:0] tap_q
);
  localparam logic [TAP_W-1:0] TAP_MAX = '1;
  localparam logic [TAP_W-1:0] INIT_V  = TAP_W'(INIT_TAP);

  logic [TAP_W-1:0] tap_nxt;
  logic             tap_en;

  always_comb begin
    tap_nxt = tap_q;
    case (op)
      OP_LOAD: tap_nxt = tap_in;
      OP_INC:  if (tap_q != TAP_MAX) tap_nxt = tap_q + 1'b1;
      OP_DEC:  if (tap_q != '0)      tap_nxt = tap_q - 1'b1;
      default: tap_nxt = tap_q;
    endcase
    if (!ctl_rdy) tap_nxt = INIT_V;
  end

  assign tap_en = (op != OP_HOLD) || !ctl_rdy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tap_q <= INIT_V;
    else if (tap_en) tap_q <= tap_nxt;
  end
endmodule

// File: rtl/tapdly_line.sv
module tapdly_line #(
  parameter int unsigned TAP_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic [TAP_W-1:0] tap,
  output logic             dout
);
  localparam int unsigned DEPTH = 2 ** TAP_W;

  logic [DEPTH-1:0] sr_q;
  logic [DEPTH-1:0] sr_nxt;

  assign sr_nxt = {sr_q[DEPTH-2:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_nxt;
  end

  // sr_q[k] holds din from k+1 cycles back
  assign dout = (tap == '0) ? din : sr_q[tap - 1'b1];
endmodule

// File: rtl/tapdly_ctl.sv
module tapdly_ctl
  import tapdly_pkg::*;
#(
  parameter dly_mode_e   MODE     = DM_LOAD,
  parameter int unsigned TAP_W    = 9,
  parameter int unsigned INIT_TAP = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_rdy,
  input  logic             vt_track,
  input  logic             tap_load,
  input  logic             step_en,
  input  logic             step_up,
  input  logic [TAP_W-1:0] tap_in,
  input  logic             din,
  output logic             dout,
  output logic [TAP_W-1:0] tap_out,
  output logic             usage_err
);
  logic    rst_meta, rst_sync_n;
  tap_op_e op;
  logic    viol;
  logic    err_nxt;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  tapdly_req_dec #(.MODE(MODE)) u_dec (
    .ctl_rdy  (ctl_rdy),
    .vt_track (vt_track),
    .tap_load (tap_load),
    .step_en  (step_en),
    .step_up  (step_up),
    .op       (op),
    .viol     (viol)
  );

  tapdly_tap_reg #(.TAP_W(TAP_W), .INIT_TAP(INIT_TAP)) u_tap (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .ctl_rdy (ctl_rdy),
    .op      (op),
    .tap_in  (tap_in),
    .tap_q   (tap_out)
  );

  tapdly_line #(.TAP_W(TAP_W)) u_line (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .din   (din),
    .tap   (tap_out),
    .dout  (dout)
  );

  assign err_nxt = usage_err | viol;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) usage_err <= 1'b0;
    else if (viol)   usage_err <= err_nxt;
  end
endmodule

// File: rtl/tapdly_ctl_chk.sv
module tapdly_ctl_chk
  import tapdly_pkg::*;
#(
  parameter dly_mode_e   MODE     = DM_LOAD,
  parameter int unsigned TAP_W    = 9,
  parameter int unsigned INIT_TAP = 100
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_rdy,
  input logic             vt_track,
  input logic             tap_load,
  input logic             step_en,
  input logic             step_up,
  input logic [TAP_W-1:0] tap_out,
  input logic             usage_err
);
  localparam logic [TAP_W-1:0] TAP_MAX = '1;
  localparam logic [TAP_W-1:0] INIT_V  = TAP_W'(INIT_TAP);

  assert_rdy_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rdy |=> (tap_out == INIT_V));

  assert_sat_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdy && tap_out == TAP_MAX && step_en && step_up && !tap_load) |=> (tap_out == TAP_MAX));

  assert_sat_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdy && tap_out == '0 && step_en && !step_up && !tap_load) |=> (tap_out == '0));

  assert_vt_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdy && vt_track) |=> (tap_out == $past(tap_out)));

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    usage_err |=> usage_err);

  assert_err_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(usage_err) |-> ($past(vt_track) || !$past(ctl_rdy)));

  generate
    if (MODE == DM_FIXED) begin : g_fixed
      assert_fixed_tap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tap_out == INIT_V);
    end
  endgenerate
endmodule

bind tapdly_ctl tapdly_ctl_chk #(.MODE(MODE), .TAP_W(TAP_W), .INIT_TAP(INIT_TAP)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctl_rdy   (ctl_rdy),
  .vt_track  (vt_track),
  .tap_load  (tap_load),
  .step_en   (step_en),
  .step_up   (step_up),
  .tap_out   (tap_out),
  .usage_err (usage_err)
);

// File: tb/tapdly_ctl_test.sv
`timescale 1ns/1ps
module tapdly_ctl_test;
  import tapdly_pkg::*;

  logic clk = 1'b0;
  logic rst_n, ctl_rdy, vt_track, tap_load, step_en, step_up, din;
  logic [8:0] tap_in;
  logic       dout_l, dout_s, dout_f;
  logic [8:0] tap_l, tap_s, tap_f;
  logic       err_l, err_s, err_f;
  int         n_chk = 0;
  int         n_bad = 0;
  logic       pat [0:15];

  always #5 clk = ~clk;

  tapdly_ctl #(.MODE(DM_LOAD), .TAP_W(9), .INIT_TAP(100)) uut (
    .clk(clk), .rst_n(rst_n), .ctl_rdy(ctl_rdy), .vt_track(vt_track), .tap_load(tap_load),
    .step_en(step_en), .step_up(step_up), .tap_in(tap_in), .din(din),
    .dout(dout_l), .tap_out(tap_l), .usage_err(err_l));

  tapdly_ctl #(.MODE(DM_STEP), .TAP_W(9), .INIT_TAP(3)) uut_var (
    .clk(clk), .rst_n(rst_n), .ctl_rdy(ctl_rdy), .vt_track(vt_track), .tap_load(tap_load),
    .step_en(step_en), .step_up(step_up), .tap_in(tap_in), .din(din),
    .dout(dout_s), .tap_out(tap_s), .usage_err(err_s));

  tapdly_ctl #(.MODE(DM_FIXED), .TAP_W(9), .INIT_TAP(7)) uut_fix (
    .clk(clk), .rst_n(rst_n), .ctl_rdy(ctl_rdy), .vt_track(vt_track), .tap_load(tap_load),
    .step_en(step_en), .step_up(step_up), .tap_in(tap_in), .din(din),
    .dout(dout_f), .tap_out(tap_f), .usage_err(err_f));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FIAL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    tap_load = 1'b0;
    step_en  = 1'b0;
    step_up  = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ctl_rdy = 1'b1; vt_track = 1'b0; din = 1'b0; tap_in = '0;
    idle();
    repeat (2) tick();
    rst_n = 1'b1;
    repeat (3) tick();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ctl_rdy = 1'b1; vt_track = 1'b0; din = 1'b0; tap_in = '0;
    idle();
    repeat (2) tick();
    chk("R1 load tap in reset", tap_l, 100);
    chk("R1 step tap in reset", tap_s, 3);
    chk("R1 fixed tap in reset", tap_f, 7);
    chk("R1 err in reset", err_l | err_s | err_f, 0);
    chk("R1 dout in reset", dout_s, 0);
    rst_n = 1'b1;
    repeat (3) tick();
    chk("R1 tap after release", tap_l, 100);
  endtask

  task automatic t_step();
    do_reset();
    step_en = 1'b1; step_up = 1'b1;
    @(negedge clk);
    chk("R10 no change before edge", tap_s, 3);
    tick();
    chk("R3 up step", tap_s, 4);
    tick();
    chk("R3 second up step", tap_s, 5);
    step_up = 1'b0;
    tick();
    chk("R3 down step", tap_s, 4);
    idle();
    tick();
    chk("R3 idle holds", tap_s, 4);
  endtask

  task automatic t_sat();
    do_reset();
    step_en = 1'b1; step_up = 1'b0;
    repeat (4) tick();
    chk("R4 floor in step mode", tap_s, 0);
    idle();
    tap_load = 1'b1; tap_in = 9'd510;
    tick();
    chk("R5 load 510", tap_l, 510);
    idle();
    step_en = 1'b1; step_up = 1'b1;
    tick();
    chk("R4 reach 511", tap_l, 511);
    tick();
    chk("R4 saturate 511", tap_l, 511);
    idle();
    tap_load = 1'b1; tap_in = 9'd1;
    tick();
    idle();
    step_en = 1'b1; step_up = 1'b0;
    tick();
    chk("R4 reach 0", tap_l, 0);
    tick();
    chk("R4 saturate 0", tap_l, 0);
    idle();
  endtask

  task automatic t_load();
    do_reset();
    tap_load = 1'b1; step_en = 1'b1; step_up = 1'b1; tap_in = 9'd42;
    tick();
    chk("R5 load wins over step", tap_l, 42);
    chk("R8 step mode ignores load", tap_s, 4);
    chk("R8 no error in step mode", err_s, 0);
    idle();
  endtask

  task automatic t_vt();
    do_reset();
    vt_track = 1'b1; step_en = 1'b1; step_up = 1'b1;
    tick();
    chk("R6 load mode count frozen", tap_l, 100);
    chk("R6 load mode err set", err_l, 1);
    chk("R6 step mode count frozen", tap_s, 3);
    chk("R6 step mode err set", err_s, 1);
    chk("R7 fixed no err with tracking", err_f, 0);
    vt_track = 1'b0; idle();
    tick();
    chk("R6 err sticky", err_s, 1);
    step_en = 1'b1; step_up = 1'b1;
    tick();
    chk("R6 step honoured after tracking off", tap_s, 4);
    idle();
    do_reset();
    chk("R6 reset clears err", err_l | err_s, 0);
  endtask

  task automatic t_rdy();
    do_reset();
    tap_load = 1'b1; tap_in = 9'd50;
    tick();
    chk("R5 load 50", tap_l, 50);
    idle();
    ctl_rdy = 1'b0;
    tick();
    chk("R2 ready low restores init", tap_l, 100);
    chk("R7 fixed err when tracking off before ready", err_f, 1);
    tap_load = 1'b1; tap_in = 9'd20; step_en = 1'b1; step_up = 1'b1;
    tick();
    chk("R2 load ignored while not ready", tap_l, 100);
    chk("R2 step ignored while not ready", tap_s, 3);
    chk("R2 no err in load mode", err_l, 0);
    idle(); ctl_rdy = 1'b1;
    tick();
    chk("R2 still init after ready", tap_l, 100);
  endtask

  task automatic t_fixed();
    do_reset();
    tap_load = 1'b1; tap_in = 9'd9; step_en = 1'b1; step_up = 1'b1;
    repeat (2) tick();
    chk("R7 fixed count unchanged", tap_f, 7);
    chk("R7 fixed no err with ready", err_f, 0);
    idle();
  endtask

  task automatic t_line();
    do_reset();
    for (int i = 0; i < 16; i++) pat[i] = 1'($urandom);
    for (int i = 0; i < 16; i++) begin
      tick();
      din = pat[i];
      @(negedge clk);
      if (i >= 3) chk("R9 delay of 3", dout_s, pat[i-3]);
    end
    step_en = 1'b1; step_up = 1'b0;
    repeat (3) tick();
    idle();
    chk("R9 count at 0", tap_s, 0);
    for (int i = 0; i < 8; i++) begin
      tick();
      din = pat[i];
      @(negedge clk);
      chk("R9 pass-through at 0", dout_s, pat[i]);
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_step();
    t_sat();
    t_load();
    t_vt();
    t_rdy();
    t_fixed();
    t_line();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule